// File: doc/BRIEF.md
# Serial Port Register Front End with Interrupt Logic

This block connects a 32-bit processor register bus to a byte-oriented serial transmitter and receiver. Software stores control words and an interrupt mask. It sends a character by writing a data-out register, and it collects received characters from a status/data word. The physical line side (bit timing, baud rate, DMA, FIFOs) is outside the block. Bytes leave on a valid/ready transmit stream and arrive on a valid/ready receive stream.

Two event sources drive the interrupt: a byte handed to the transmitter and a byte taken from the receiver. Each one sets a raw interrupt bit. Software clears raw bits by writing ones to an acknowledge location, and a mask selects which raw bits reach the single interrupt line. Reading the status/data word at one offset clears the data-available flag; a second offset returns the same word with no side effect. The receive stream refuses new bytes while a receive interrupt is pending and the receiver is not enabled.

The register bus uses one-cycle read and write strobes. Read data comes from a register and is valid the cycle after the read strobe. A data-out write is held off with a wait signal until the transmitter can take the byte.

Top module: `uart_regfront`

## Requirements
- R1: After reset the status word reads 0x0140_0000 (transmitter idle at bit 22 and transmitter ready at bit 24 set, everything else clear). Every other mapped register reads zero and `irq` is low.
- R2: Offsets 0x00, 0x04, 0x08 and 0x2C are read/write storage that return the last value written. Writes to 0x24, 0x34 and 0x38 change nothing. Offset 0x30 and all unmapped offsets within the 4 KiB window read zero. Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R3: A write to 0x1C raises `tx_valid` with the low byte of the write data on `tx_data` during that write. `bus_wait` stays high while `tx_ready` is low. When the byte is accepted, raw interrupt bit 0 is set and a transmit-pending flag is set.
- R4: A byte accepted on the receive stream replaces status bits 7:0, sets data-available (bit 16) and sets raw interrupt bit 3.
- R5: A read at 0x20 returns the status word and then clears bit 16. A read at 0x24 returns the same word and leaves it unchanged.
- R6: A write to 0x30 clears every raw interrupt bit at which the written value is 1. The acknowledge value is not kept.
- R7: A write to 0x30 with bit 0 set while transmit-pending is 1 leaves raw bit 0 set and clears transmit-pending. A later such write then clears raw bit 0.
- R8: Offset 0x34 reads the raw interrupts and 0x38 reads raw AND mask. `irq` is high exactly when raw AND mask is nonzero, updated one cycle after the event that changes it.
- R9: `rx_ready` is high when bit 0 of the receive control register (0x08) is 1 or raw interrupt bit 3 is 0. A byte offered while `rx_ready` is low is dropped without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, held while `bus_wait` is high |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | ADDR_W | Byte address, low 12 bits decoded |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| bus_wait | output | 1 | Write stall while the transmitter is busy |
| tx_data | output | CHAR_W | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter accepts byte |
| rx_data | input | CHAR_W | Received byte |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Block accepts received byte |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit bus, 8-bit characters, 12 address bits and the unregistered interrupt output. With these values every status bit position and every offset in the window is directly reachable, and the one-cycle `irq` latency can be checked exactly. Random sequences of writes (including acknowledge values that hit the pending transmit), reads at both status offsets and receive offers with the receive path both open and blocked are checked against a bench model of raw, mask, pending and data-available state.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
   localparam int OFS_TXCTL   = 'h00;
   localparam int OFS_TXDMA   = 'h04;
   localparam int OFS_RXCTL   = 'h08;
   localparam int OFS_DOUT    = 'h1C;
   localparam int OFS_STAT_RC = 'h20;
   localparam int OFS_STAT    = 'h24;
   localparam int OFS_MASK    = 'h2C;
   localparam int OFS_ACK     = 'h30;
   localparam int OFS_RAW     = 'h34;
   localparam int OFS_MSKD    = 'h38;

   localparam int WIN_W     = 12;
   localparam int BIT_DAV   = 16;
   localparam int BIT_TIDLE = 22;
   localparam int BIT_TRDY  = 24;
   localparam int IRQ_TX    = 0;
   localparam int IRQ_RX    = 3;

   typedef struct packed {
      logic txctl;
      logic txdma;
      logic rxctl;
      logic dout;
      logic stat_rc;
      logic stat;
      logic mask;
      logic ack;
      logic raw;
      logic mskd;
   } reg_sel_t;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
   import uart_regfront_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);
   logic [WIN_W-1:0] ofs;
   assign ofs = addr[WIN_W-1:0];

   always_comb begin
      sel         = '0;
      sel.txctl   = (ofs == WIN_W'(OFS_TXCTL));
      sel.txdma   = (ofs == WIN_W'(OFS_TXDMA));
      sel.rxctl   = (ofs == WIN_W'(OFS_RXCTL));
      sel.dout    = (ofs == WIN_W'(OFS_DOUT));
      sel.stat_rc = (ofs == WIN_W'(OFS_STAT_RC));
      sel.stat    = (ofs == WIN_W'(OFS_STAT));
      sel.mask    = (ofs == WIN_W'(OFS_MASK));
      sel.ack     = (ofs == WIN_W'(OFS_ACK));
      sel.raw     = (ofs == WIN_W'(OFS_RAW));
      sel.mskd    = (ofs == WIN_W'(OFS_MSKD));
   end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
   import uart_regfront_pkg::*;
#(
   parameter int BUS_W       = 32,
   parameter bit IRQ_OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_ok,
   input  reg_sel_t         sel,
   input  logic [BUS_W-1:0] wdata,
   input  logic             rx_take,
   output logic [BUS_W-1:0] raw,
   output logic [BUS_W-1:0] mask,
   output logic             irq
);
   logic [BUS_W-1:0] raw_q, raw_n, mask_q, mask_n, ackv;
   logic             pend_q, pend_n;
   logic             any_masked;

   // Event step followed by the ordered update: acknowledge clear, then mask.
   always_comb begin
      raw_n  = raw_q;
      mask_n = mask_q;
      pend_n = pend_q;
      ackv   = '0;
      if (wr_ok) begin
         if (sel.mask) mask_n = wdata;
         if (sel.dout) begin
            raw_n[IRQ_TX] = 1'b1;
            pend_n        = 1'b1;
         end
         if (sel.ack) begin
            ackv = wdata;
            if (pend_q && wdata[IRQ_TX]) begin
               raw_n[IRQ_TX] = 1'b1;
               pend_n        = 1'b0;
               ackv[IRQ_TX]  = 1'b0;
            end
         end
         raw_n = raw_n & ~ackv;
      end
      if (rx_take) raw_n[IRQ_RX] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         raw_q  <= '0;
         mask_q <= '0;
         pend_q <= 1'b0;
      end else begin
         raw_q  <= raw_n;
         mask_q <= mask_n;
         pend_q <= pend_n;
      end
   end

   assign raw        = raw_q;
   assign mask       = mask_q;
   assign any_masked = |(raw_q & mask_q);

   generate
      if (IRQ_OUT_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (rst) irq_q <= 1'b0;
            else     irq_q <= any_masked;
         end
         assign irq = irq_q;
      end else begin : g_irq_direct
         assign irq = any_masked;
      end
   endgenerate
endmodule

// File: rtl/uart_rf_rx.sv
module uart_rf_rx
   import uart_regfront_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_ok,
   input  logic              rd,
   input  reg_sel_t          sel,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              raw_rx,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic              rx_take,
   output logic [BUS_W-1:0]  rxctl,
   output logic [BUS_W-1:0]  stat
);
   logic [CHAR_W-1:0] byte_q;
   logic              dav_q;
   logic [BUS_W-1:0]  rxctl_q;

   assign rx_ready = rxctl_q[0] | ~raw_rx;
   assign rx_take  = rx_valid & rx_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         byte_q  <= '0;
         dav_q   <= 1'b0;
         rxctl_q <= '0;
      end else begin
         if (wr_ok && sel.rxctl) rxctl_q <= wdata;
         if (rx_take) begin
            byte_q <= rx_data;
            dav_q  <= 1'b1;
         end else if (rd && sel.stat_rc) begin
            dav_q  <= 1'b0;
         end
      end
   end

   always_comb begin
      stat              = '0;
      stat[CHAR_W-1:0]  = byte_q;
      stat[BIT_DAV]     = dav_q;
      stat[BIT_TIDLE]   = 1'b1;
      stat[BIT_TRDY]    = 1'b1;
   end

   assign rxctl = rxctl_q;
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_regfront_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int BUS_W       = 32,
   parameter int CHAR_W      = 8,
   parameter bit IRQ_OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              bus_wait,
   output logic [CHAR_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic              irq
);
   generate
      if (ADDR_W < WIN_W) begin : g_chk_addr
         $error("ADDR_W must cover the 4 KiB register window");
      end
      if (BUS_W <= BIT_TRDY) begin : g_chk_bus
         $error("BUS_W too narrow for the status word");
      end
      if (CHAR_W < 1 || CHAR_W > BIT_DAV) begin : g_chk_char
         $error("CHAR_W must fit below the data-available bit");
      end
   endgenerate

   reg_sel_t         sel;
   logic             wr_ok, rx_take;
   logic [BUS_W-1:0] irq_raw, irq_mask, rxctl, stat;
   logic [BUS_W-1:0] txctl_q, txdma_q, rmux, rdata_q;

   uart_rf_decode #(.ADDR_W(ADDR_W)) dec_i (.addr(bus_addr), .sel(sel));

   assign tx_valid = bus_wr & sel.dout;
   assign tx_data  = bus_wdata[CHAR_W-1:0];
   assign bus_wait = tx_valid & ~tx_ready;
   assign wr_ok    = bus_wr & ~bus_wait;

   uart_rf_irq #(.BUS_W(BUS_W), .IRQ_OUT_REG(IRQ_OUT_REG)) irq_i (
      .clk(clk), .rst(rst), .wr_ok(wr_ok), .sel(sel), .wdata(bus_wdata),
      .rx_take(rx_take), .raw(irq_raw), .mask(irq_mask), .irq(irq)
   );

   uart_rf_rx #(.BUS_W(BUS_W), .CHAR_W(CHAR_W)) rx_i (
      .clk(clk), .rst(rst), .wr_ok(wr_ok), .rd(bus_rd), .sel(sel),
      .wdata(bus_wdata), .raw_rx(irq_raw[IRQ_RX]), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_take(rx_take),
      .rxctl(rxctl), .stat(stat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         txctl_q <= '0;
         txdma_q <= '0;
      end else if (wr_ok) begin
         if (sel.txctl) txctl_q <= bus_wdata;
         if (sel.txdma) txdma_q <= bus_wdata;
      end
   end

   always_comb begin
      rmux = '0;
      if (sel.txctl)              rmux = rmux | txctl_q;
      if (sel.txdma)              rmux = rmux | txdma_q;
      if (sel.rxctl)              rmux = rmux | rxctl;
      if (sel.stat_rc | sel.stat) rmux = rmux | stat;
      if (sel.mask)               rmux = rmux | irq_mask;
      if (sel.raw)                rmux = rmux | irq_raw;
      if (sel.mskd)               rmux = rmux | (irq_raw & irq_mask);
   end

   always_ff @(posedge clk) begin
      if (rst)         rdata_q <= '0;
      else if (bus_rd) rdata_q <= rmux;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
   import uart_regfront_pkg::*;
#(
   parameter int BUS_W       = 32,
   parameter bit IRQ_OUT_REG = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic             bus_wr,
   input logic             bus_wait,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic             rx_valid,
   input logic             rx_ready,
   input logic             irq,
   input logic [BUS_W-1:0] irq_raw
);
   localparam int LAT = 1 + int'(IRQ_OUT_REG);

   // R3: an accepted transmit leaves the transmit interrupt set
   a_r3_tx_sets_raw: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && tx_ready) |=> irq_raw[IRQ_TX]);

   // R3: a stalled write never coincides with an accepted transfer
   a_r3_wait_only_busy: assert property (@(posedge clk) disable iff (rst)
      bus_wait |-> !tx_ready);

   // R4: an accepted receive leaves the receive interrupt set
   a_r4_rx_sets_raw: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && rx_ready) |=> irq_raw[IRQ_RX]);

   // R6: raw interrupts change only after a bus write or a receive offer
   a_r6_raw_event_only: assert property (@(posedge clk) disable iff (rst)
      !$stable(irq_raw) |-> $past(bus_wr || rx_valid));

   // R8: the interrupt line rises only after a write or a receive offer
   a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> $past(bus_wr || rx_valid, LAT));

   // R9: the receive path closes only after a byte or a control write
   a_r9_ready_fall_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(rx_ready) |-> $past(bus_wr || rx_valid));
endmodule

bind uart_regfront uart_regfront_chk #(.BUS_W(BUS_W), .IRQ_OUT_REG(IRQ_OUT_REG)) chk_i (
   .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wait(bus_wait),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
   .rx_ready(rx_ready), .irq(irq), .irq_raw(irq_raw)
);

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb_top;
   localparam int ADDR_W = 12;
   localparam int BUS_W  = 32;
   localparam int CHAR_W = 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              bus_wr = 1'b0, bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [BUS_W-1:0]  bus_wdata = '0;
   logic [BUS_W-1:0]  bus_rdata;
   logic              bus_wait, tx_valid, rx_ready, irq;
   logic              tx_ready = 1'b1;
   logic [CHAR_W-1:0] tx_data;
   logic [CHAR_W-1:0] rx_data = '0;
   logic              rx_valid = 1'b0;

   always #2.5 clk = ~clk;

   uart_regfront #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CHAR_W(CHAR_W)) dut_i (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_wait(bus_wait), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .irq(irq)
   );

   int n_chk = 0, n_bad = 0;

   // bench model state
   logic [31:0] m_txctl, m_txdma, m_rxctl, m_mask, m_raw;
   logic        m_pend, m_dav;
   logic [7:0]  m_byte;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_stat();
      return 32'h0140_0000 | {15'd0, m_dav, 8'd0, m_byte};
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a);
      case (a)
         12'h000: return m_txctl;
         12'h004: return m_txdma;
         12'h008: return m_rxctl;
         12'h020, 12'h024: return m_stat();
         12'h02C: return m_mask;
         12'h034: return m_raw;
         12'h038: return m_raw & m_mask;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic m_irq();
      return |(m_raw & m_mask);
   endfunction

   task automatic m_reset();
      m_txctl = 0; m_txdma = 0; m_rxctl = 0; m_mask = 0; m_raw = 0;
      m_pend = 0; m_dav = 0; m_byte = 0;
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input int stall);
      logic [31:0] v;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tx_ready = (stall == 0);
      for (int i = 0; i < stall; i++) begin
         #1;
         chk({31'd0, bus_wait}, 32'd1, "R3 wait while busy");
         chk({23'd0, tx_valid, tx_data}, {23'd0, 1'b1, d[7:0]}, "R3 byte on stream");
         @(negedge clk);
      end
      tx_ready = 1'b1;
      #1;
      chk({31'd0, bus_wait}, 32'd0, "R3 wait released");
      if (a == 12'h01C)
         chk({23'd0, tx_valid, tx_data}, {23'd0, 1'b1, d[7:0]}, "R3 byte accepted");
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         12'h000: m_txctl = d;
         12'h004: m_txdma = d;
         12'h008: m_rxctl = d;
         12'h02C: m_mask  = d;
         12'h01C: begin m_raw[0] = 1'b1; m_pend = 1'b1; end
         12'h030: begin
            v = d;
            if (m_pend && v[0]) begin m_raw[0] = 1'b1; m_pend = 1'b0; v[0] = 1'b0; end
            m_raw = m_raw & ~v;
         end
         default: ;
      endcase
      chk({31'd0, irq}, {31'd0, m_irq()}, "R8 irq after write");
   endtask

   task automatic bus_read(input logic [11:0] a, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(bus_rdata, m_read(a), tag);
      if (a == 12'h020) m_dav = 1'b0;
   endtask

   task automatic rx_send(input logic [7:0] b);
      logic exp_rdy;
      exp_rdy = m_rxctl[0] | ~m_raw[3];
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      #1;
      chk({31'd0, rx_ready}, {31'd0, exp_rdy}, "R9 rx_ready");
      @(negedge clk);
      rx_valid = 1'b0;
      if (exp_rdy) begin m_byte = b; m_dav = 1'b1; m_raw[3] = 1'b1; end
      chk({31'd0, irq}, {31'd0, m_irq()}, "R8 irq after receive");
   endtask

   localparam logic [11:0] OFS_LIST [0:10] = '{12'h000, 12'h004, 12'h008, 12'h01C,
      12'h020, 12'h024, 12'h02C, 12'h030, 12'h034, 12'h038, 12'h040};

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      m_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      chk({31'd0, irq}, 32'd0, "R1 irq low");
      foreach (OFS_LIST[k]) bus_read(OFS_LIST[k], "R1 reset read");
      bus_read(12'h024, "R1 status word");

      // R2 plain storage and ignored writes
      bus_write(12'h000, 32'hDEAD_BEEF, 0);
      bus_write(12'h004, 32'h0000_0001, 0);
      bus_write(12'h008, 32'h1234_5670, 0);
      bus_write(12'h02C, 32'h0000_0009, 0);
      bus_write(12'h024, 32'hFFFF_FFFF, 0);
      bus_write(12'h034, 32'hFFFF_FFFF, 0);
      bus_write(12'h038, 32'hFFFF_FFFF, 0);
      bus_write(12'h07C, 32'hFFFF_FFFF, 0);
      foreach (OFS_LIST[k]) bus_read(OFS_LIST[k], "R2 readback");

      // R3 stalled transmit, R7 double acknowledge
      bus_write(12'h01C, 32'hAB12_345A, 3);
      bus_read(12'h034, "R3 raw tx set");
      bus_write(12'h030, 32'h0000_0001, 0);
      bus_read(12'h034, "R7 raw tx re-armed");
      bus_write(12'h030, 32'h0000_0001, 0);
      bus_read(12'h034, "R7 raw tx cleared");

      // R4, R5 receive and status read side effect
      rx_send(8'hA5);
      bus_read(12'h024, "R4 status after receive");
      bus_read(12'h020, "R5 clearing read");
      bus_read(12'h024, "R5 data-available cleared");
      bus_read(12'h038, "R8 masked");

      // R9 blocked receive dropped, then enabled
      rx_send(8'h3C);
      bus_read(12'h024, "R9 dropped byte");
      bus_write(12'h008, 32'h0000_0001, 0);
      rx_send(8'h3C);
      bus_read(12'h024, "R9 accepted byte");

      // R6 acknowledge of receive interrupt
      bus_write(12'h030, 32'h0000_0008, 0);
      bus_read(12'h034, "R6 raw rx cleared");

      // random mix
      for (int it = 0; it < 600; it++) begin
         int op;
         op = int'($urandom_range(0, 9));
         case (op)
            0: bus_write(12'h01C, $urandom, int'($urandom_range(0, 2)));
            1, 2: bus_write(12'h030, $urandom & 32'h0000_000F, 0);
            3: bus_write(12'h02C, $urandom & 32'h0000_000F, 0);
            4: bus_write(12'h008, $urandom & 32'h0000_0001, 0);
            5, 6: rx_send(8'($urandom));
            default: bus_read(OFS_LIST[$urandom_range(0, 10)], "R2 R5 R8 random read");
         endcase
      end
      foreach (OFS_LIST[k]) bus_read(OFS_LIST[k], "R8 final readback");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule